// File: doc/BRIEF.md
# Pseudo-Associative Direct-Mapped Cache Controller

This block is a direct-mapped cache that recovers part of the conflict-miss loss of a plain direct-mapped organisation. Every line has a partner slot, found by flipping the top bit of the index. A lookup first probes the primary slot. On a miss it probes the partner slot. A block found there is returned one cycle later as a slow hit, and the two lines trade places, so the next access to that block is a fast hit. When both probes miss, the controller fetches the whole block from lower-level memory and writes it into the primary slot. The line that held the primary slot moves into the partner slot.

The CPU side takes a one-cycle request pulse carrying a word address, a write flag and write data. Every completed request returns a one-cycle done strobe with read data and a 2-bit access class, so latency can be measured per access. Writes are write-through. Each write produces one word write on the memory port. A write that hits updates the cached copy. A write that misses both slots allocates nothing. The memory side has a block-read request held until the fill data returns, plus a one-cycle word-write strobe.

Top module: `pac_cache`

## Requirements
- R1: If the primary slot holds the requested block, `cpu_done` is high with class 2'b01 (fast hit) in the cycle right after the edge that accepted the request.
- R2: If the primary slot misses, the second probe examines only the slot whose index equals the request index with its most significant bit inverted.
- R3: A hit in the partner slot is a pseudo-hit. `cpu_done` is high with class 2'b10 two cycles after the accepting edge.
- R4: After a pseudo-hit, the hit block sits in the primary slot and the former primary line sits in the partner slot. An immediate repeat access to the block is therefore a fast hit, and an access to the displaced block is a pseudo-hit.
- R5: A read that misses both slots raises `mem_rd_req` with block address {tag, index} and keeps it high until `mem_rd_valid`. It returns class 2'b11 one cycle after the fill is accepted, with the requested word taken from the fetched line. Word offset k occupies line bits [32k+31:32k].
- R6: Each stored tag includes the most significant index bit. A block held in the partner slot never matches an address that differs from it only in that index bit.
- R7: On a read miss, the fetched block is placed in the primary slot. A valid former primary line moves into the partner slot and evicts whatever was there.
- R8: Every write emits exactly one `mem_wr` pulse, carrying the request address and data, in the same cycle as `cpu_done`. A write that hits (fast or pseudo) also updates the cached word.
- R9: A write that misses both slots allocates no line and issues no block fetch. It completes two cycles after the accepting edge with class 2'b11.
- R10: Reset invalidates every line and holds `cpu_done`, `mem_rd_req` and `mem_wr` low. The class output reads 2'b00 in every cycle without a response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_req | input | 1 | One-cycle request pulse, accepted when the controller is idle |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | 10 | Word address {tag, index, offset} |
| cpu_wdata | input | 32 | Write data |
| cpu_done | output | 1 | Response strobe |
| cpu_class | output | 2 | 00 none, 01 fast hit, 10 pseudo-hit, 11 miss |
| cpu_rdata | output | 32 | Read data, valid with `cpu_done` |
| mem_rd_req | output | 1 | Block fetch request, held until fill data returns |
| mem_rd_addr | output | 9 | Block address {tag, index} |
| mem_rd_valid | input | 1 | Fill data present on `mem_rd_line` |
| mem_rd_line | input | 64 | Fetched block, word 0 in the low half |
| mem_wr | output | 1 | Write-through strobe |
| mem_wr_addr | output | 10 | Write-through word address |
| mem_wr_data | output | 32 | Write-through data |

## Verification
A directed chain drives three blocks with different tags into one index pair, and the bench checks the class at every step. The chain shows that a second lookup finds the block that was pushed aside, that the swap puts it back on the fast path, and that a third block evicts the oldest copy. One address differs from a cached block only in the top index bit. It must miss, which separates a tag that carries that bit from one that does not. Writes are driven as fast hits, pseudo-hits and cold misses, and reads follow them to confirm the cached copy and the no-allocate rule. A seeded random stream over four tags and all indices then mixes reads and writes, and a reference slot model predicts the class, latency and data of each access.

// File: rtl/pac_pkg.sv
package pac_pkg;
    localparam int ADDR_W     = 10;
    localparam int DATA_W     = 32;
    localparam int OFF_W      = 1;
    localparam int IDX_W      = 3;
    localparam int LINE_WORDS = 1 << OFF_W;
    localparam int LINES      = 1 << IDX_W;
    localparam int TAG_W      = ADDR_W - IDX_W - OFF_W;
    localparam int STAG_W     = TAG_W + 1;
    localparam int LINE_W     = LINE_WORDS * DATA_W;
    localparam int BLK_W      = ADDR_W - OFF_W;

    typedef enum logic [1:0] {
        CLS_NONE   = 2'd0,
        CLS_FAST   = 2'd1,
        CLS_PSEUDO = 2'd2,
        CLS_MISS   = 2'd3
    } acc_class_e;

    typedef enum logic [1:0] {
        S_IDLE  = 2'd0,
        S_PROBE = 2'd1,
        S_FILL  = 2'd2
    } ctl_state_e;

    typedef struct packed {
        logic [TAG_W-1:0] tag;
        logic [IDX_W-1:0] idx;
        logic [OFF_W-1:0] off;
    } addr_t;

    typedef struct packed {
        logic              valid;
        logic [STAG_W-1:0] stag;
        logic [LINE_W-1:0] data;
    } line_t;

    function automatic logic [IDX_W-1:0] partner_idx(input logic [IDX_W-1:0] i);
        return i ^ (IDX_W'(1) << (IDX_W - 1));
    endfunction

    function automatic logic [STAG_W-1:0] stored_tag(input addr_t a);
        return {a.tag, a.idx[IDX_W-1]};
    endfunction

    function automatic logic [DATA_W-1:0] pick_word(input logic [LINE_W-1:0] d,
                                                    input logic [OFF_W-1:0] o);
        return d[int'(o)*DATA_W +: DATA_W];
    endfunction

    function automatic logic [LINE_W-1:0] put_word(input logic [LINE_W-1:0] d,
                                                   input logic [OFF_W-1:0] o,
                                                   input logic [DATA_W-1:0] w);
        logic [LINE_W-1:0] r;
        r = d;
        r[int'(o)*DATA_W +: DATA_W] = w;
        return r;
    endfunction
endpackage

// File: rtl/pac_line_store.sv
module pac_line_store
    import pac_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [IDX_W-1:0] rd_a_idx,
    output line_t            rd_a,
    input  logic [IDX_W-1:0] rd_b_idx,
    output line_t            rd_b,
    input  logic             wa_en,
    input  logic [IDX_W-1:0] wa_idx,
    input  line_t            wa_line,
    input  logic             wb_en,
    input  logic [IDX_W-1:0] wb_idx,
    input  line_t            wb_line
);
    logic              valid_q [LINES];
    logic [STAG_W-1:0] stag_q  [LINES];
    logic [LINE_W-1:0] data_q  [LINES];

    for (genvar g = 0; g < LINES; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst) begin
                valid_q[g] <= 1'b0;
            end else if (wa_en && wa_idx == IDX_W'(g)) begin
                valid_q[g] <= wa_line.valid;
            end else if (wb_en && wb_idx == IDX_W'(g)) begin
                valid_q[g] <= wb_line.valid;
            end
        end

        always_ff @(posedge clk) begin
            if (wa_en && wa_idx == IDX_W'(g)) begin
                stag_q[g] <= wa_line.stag;
                data_q[g] <= wa_line.data;
            end else if (wb_en && wb_idx == IDX_W'(g)) begin
                stag_q[g] <= wb_line.stag;
                data_q[g] <= wb_line.data;
            end
        end
    end

    always_comb begin
        rd_a = '{valid: valid_q[rd_a_idx], stag: stag_q[rd_a_idx], data: data_q[rd_a_idx]};
        rd_b = '{valid: valid_q[rd_b_idx], stag: stag_q[rd_b_idx], data: data_q[rd_b_idx]};
    end

    // R4: a swap or a displacement must touch two different slots
    assert_swap_distinct_R4: assert property (@(posedge clk) disable iff (rst)
        (wa_en && wb_en) |-> (wa_idx != wb_idx));
endmodule

// File: rtl/pac_ctrl.sv
module pac_ctrl
    import pac_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic              cpu_done,
    output logic [1:0]        cpu_class,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic              mem_rd_req,
    output logic [BLK_W-1:0]  mem_rd_addr,
    input  logic              mem_rd_valid,
    input  logic [LINE_W-1:0] mem_rd_line,
    output logic              mem_wr,
    output logic [ADDR_W-1:0] mem_wr_addr,
    output logic [DATA_W-1:0] mem_wr_data,
    output logic [IDX_W-1:0]  a_idx,
    input  line_t             a_line,
    output logic [IDX_W-1:0]  b_idx,
    input  line_t             b_line,
    output logic              wa_en,
    output logic [IDX_W-1:0]  wa_idx,
    output line_t             wa_line,
    output logic              wb_en,
    output logic [IDX_W-1:0]  wb_idx,
    output line_t             wb_line
);
    ctl_state_e        state_q;
    addr_t             lat_addr_q;
    logic              lat_we_q;
    logic [DATA_W-1:0] lat_wdata_q;
    logic              done_q;
    acc_class_e        cls_q;
    logic [DATA_W-1:0] rdata_q;
    logic              rd_req_q;
    logic              wr_q;
    logic [ADDR_W-1:0] wr_addr_q;
    logic [DATA_W-1:0] wr_data_q;

    addr_t cur;
    logic  a_hit;
    logic  b_hit;

    assign cur    = (state_q == S_IDLE) ? addr_t'(cpu_addr) : lat_addr_q;
    assign a_idx  = cur.idx;
    assign b_idx  = partner_idx(cur.idx);
    assign wa_idx = a_idx;
    assign wb_idx = b_idx;
    assign a_hit  = a_line.valid && (a_line.stag == stored_tag(cur));
    assign b_hit  = b_line.valid && (b_line.stag == stored_tag(cur));

    always_comb begin
        wa_en   = 1'b0;
        wa_line = a_line;
        wb_en   = 1'b0;
        wb_line = a_line;
        unique case (state_q)
            S_IDLE: begin
                if (cpu_req && a_hit && cpu_we) begin
                    wa_en        = 1'b1;
                    wa_line.data = put_word(a_line.data, cur.off, cpu_wdata);
                end
            end
            S_PROBE: begin
                if (b_hit) begin
                    wa_en   = 1'b1;
                    wa_line = b_line;
                    if (lat_we_q) begin
                        wa_line.data = put_word(b_line.data, cur.off, lat_wdata_q);
                    end
                    wb_en   = 1'b1;
                    wb_line = a_line;
                end
            end
            S_FILL: begin
                if (mem_rd_valid) begin
                    wa_en   = 1'b1;
                    wa_line = '{valid: 1'b1, stag: stored_tag(cur), data: mem_rd_line};
                    wb_en   = a_line.valid;
                    wb_line = a_line;
                end
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q     <= S_IDLE;
            lat_addr_q  <= '0;
            lat_we_q    <= 1'b0;
            lat_wdata_q <= '0;
            done_q      <= 1'b0;
            cls_q       <= CLS_NONE;
            rdata_q     <= '0;
            rd_req_q    <= 1'b0;
            wr_q        <= 1'b0;
            wr_addr_q   <= '0;
            wr_data_q   <= '0;
        end else begin
            done_q <= 1'b0;
            cls_q  <= CLS_NONE;
            wr_q   <= 1'b0;
            unique case (state_q)
                S_IDLE: begin
                    if (cpu_req) begin
                        lat_addr_q  <= cur;
                        lat_we_q    <= cpu_we;
                        lat_wdata_q <= cpu_wdata;
                        if (a_hit) begin
                            done_q    <= 1'b1;
                            cls_q     <= CLS_FAST;
                            rdata_q   <= pick_word(a_line.data, cur.off);
                            wr_q      <= cpu_we;
                            wr_addr_q <= cpu_addr;
                            wr_data_q <= cpu_wdata;
                        end else begin
                            state_q <= S_PROBE;
                        end
                    end
                end
                S_PROBE: begin
                    wr_addr_q <= lat_addr_q;
                    wr_data_q <= lat_wdata_q;
                    if (b_hit) begin
                        done_q  <= 1'b1;
                        cls_q   <= CLS_PSEUDO;
                        rdata_q <= pick_word(b_line.data, cur.off);
                        wr_q    <= lat_we_q;
                        state_q <= S_IDLE;
                    end else if (lat_we_q) begin
                        done_q  <= 1'b1;
                        cls_q   <= CLS_MISS;
                        wr_q    <= 1'b1;
                        state_q <= S_IDLE;
                    end else begin
                        rd_req_q <= 1'b1;
                        state_q  <= S_FILL;
                    end
                end
                S_FILL: begin
                    if (mem_rd_valid) begin
                        rd_req_q <= 1'b0;
                        done_q   <= 1'b1;
                        cls_q    <= CLS_MISS;
                        rdata_q  <= pick_word(mem_rd_line, cur.off);
                        state_q  <= S_IDLE;
                    end
                end
                default: state_q <= S_IDLE;
            endcase
        end
    end

    assign cpu_done    = done_q;
    assign cpu_class   = cls_q;
    assign cpu_rdata   = rdata_q;
    assign mem_rd_req  = rd_req_q;
    assign mem_rd_addr = {lat_addr_q.tag, lat_addr_q.idx};
    assign mem_wr      = wr_q;
    assign mem_wr_addr = wr_addr_q;
    assign mem_wr_data = wr_data_q;

    assert_fast_latency_R1: assert property (@(posedge clk) disable iff (rst)
        (state_q == S_IDLE && cpu_req && a_hit) |=> (cpu_done && cpu_class == CLS_FAST));

    assert_pseudo_path_R3: assert property (@(posedge clk) disable iff (rst)
        (cpu_done && cpu_class == CLS_PSEUDO) |-> ($past(state_q) == S_PROBE && $past(state_q, 2) == S_IDLE));

    assert_fill_hold_R5: assert property (@(posedge clk) disable iff (rst)
        (mem_rd_req && !mem_rd_valid) |=> mem_rd_req);

    assert_write_nofill_R9: assert property (@(posedge clk) disable iff (rst)
        (state_q == S_PROBE && lat_we_q) |=> !mem_rd_req);

    assert_class_quiet_R10: assert property (@(posedge clk) disable iff (rst)
        !cpu_done |-> (cpu_class == CLS_NONE));

    assert_wr_with_done_R8: assert property (@(posedge clk) disable iff (rst)
        mem_wr |-> cpu_done);
endmodule

// File: rtl/pac_cache.sv
module pac_cache
    import pac_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic              cpu_done,
    output logic [1:0]        cpu_class,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic              mem_rd_req,
    output logic [BLK_W-1:0]  mem_rd_addr,
    input  logic              mem_rd_valid,
    input  logic [LINE_W-1:0] mem_rd_line,
    output logic              mem_wr,
    output logic [ADDR_W-1:0] mem_wr_addr,
    output logic [DATA_W-1:0] mem_wr_data
);
    logic [IDX_W-1:0] a_idx, b_idx, wa_idx, wb_idx;
    line_t            a_line, b_line, wa_line, wb_line;
    logic             wa_en, wb_en;

    pac_ctrl u_ctrl (
        .clk(clk), .rst(rst),
        .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .cpu_done(cpu_done), .cpu_class(cpu_class), .cpu_rdata(cpu_rdata),
        .mem_rd_req(mem_rd_req), .mem_rd_addr(mem_rd_addr),
        .mem_rd_valid(mem_rd_valid), .mem_rd_line(mem_rd_line),
        .mem_wr(mem_wr), .mem_wr_addr(mem_wr_addr), .mem_wr_data(mem_wr_data),
        .a_idx(a_idx), .a_line(a_line), .b_idx(b_idx), .b_line(b_line),
        .wa_en(wa_en), .wa_idx(wa_idx), .wa_line(wa_line),
        .wb_en(wb_en), .wb_idx(wb_idx), .wb_line(wb_line)
    );

    pac_line_store u_store (
        .clk(clk), .rst(rst),
        .rd_a_idx(a_idx), .rd_a(a_line),
        .rd_b_idx(b_idx), .rd_b(b_line),
        .wa_en(wa_en), .wa_idx(wa_idx), .wa_line(wa_line),
        .wb_en(wb_en), .wb_idx(wb_idx), .wb_line(wb_line)
    );

    // R2: the second probe always reads the slot with the inverted top index bit
    assert_partner_probe_R2: assert property (@(posedge clk) disable iff (rst)
        wb_en |-> (wb_idx == (wa_idx ^ (IDX_W'(1) << (IDX_W - 1)))));
endmodule

// File: tb/pac_cache_bench.sv
module pac_cache_bench;
    import pac_pkg::*;

    localparam int MEM_LAT  = 4;
    localparam int MEM_SIZE = 1 << ADDR_W;
    localparam int SEED     = 1234;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              cpu_req = 1'b0;
    logic              cpu_we = 1'b0;
    logic [ADDR_W-1:0] cpu_addr = '0;
    logic [DATA_W-1:0] cpu_wdata = '0;
    logic              cpu_done;
    logic [1:0]        cpu_class;
    logic [DATA_W-1:0] cpu_rdata;
    logic              mem_rd_req;
    logic [BLK_W-1:0]  mem_rd_addr;
    logic              mem_rd_valid = 1'b0;
    logic [LINE_W-1:0] mem_rd_line = '0;
    logic              mem_wr;
    logic [ADDR_W-1:0] mem_wr_addr;
    logic [DATA_W-1:0] mem_wr_data;

    always #4 clk = ~clk;

    pac_cache u_pac_cache (
        .clk(clk), .rst(rst),
        .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .cpu_done(cpu_done), .cpu_class(cpu_class), .cpu_rdata(cpu_rdata),
        .mem_rd_req(mem_rd_req), .mem_rd_addr(mem_rd_addr),
        .mem_rd_valid(mem_rd_valid), .mem_rd_line(mem_rd_line),
        .mem_wr(mem_wr), .mem_wr_addr(mem_wr_addr), .mem_wr_data(mem_wr_data)
    );

    int n_chk = 0;
    int n_fail = 0;
    int wr_cnt = 0;
    int fill_cnt = 0;
    bit finished = 1'b0;

    logic [DATA_W-1:0] gmem [MEM_SIZE];
    bit                mv [LINES];
    logic [STAG_W-1:0] ms [LINES];

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [ADDR_W-1:0] mk(input int t, input int i, input int o);
        addr_t a;
        a.tag = TAG_W'(t);
        a.idx = IDX_W'(i);
        a.off = OFF_W'(o);
        return ADDR_W'(a);
    endfunction

    // memory fill responder
    initial begin
        logic [LINE_W-1:0] ln;
        forever begin
            @(negedge clk);
            if (mem_rd_req && !mem_rd_valid) begin
                fill_cnt++;
                repeat (MEM_LAT - 1) @(negedge clk);
                for (int w = 0; w < LINE_WORDS; w++) begin
                    ln[w*DATA_W +: DATA_W] = gmem[{mem_rd_addr, OFF_W'(w)}];
                end
                mem_rd_line  = ln;
                mem_rd_valid = 1'b1;
                @(negedge clk);
                mem_rd_valid = 1'b0;
            end
        end
    end

    // write-through sink
    initial begin
        forever begin
            @(negedge clk);
            if (mem_wr) begin
                gmem[mem_wr_addr] = mem_wr_data;
                wr_cnt++;
            end
        end
    end

    task automatic access(input bit we, input logic [ADDR_W-1:0] a,
                          input logic [DATA_W-1:0] wd, input string ctx);
        addr_t             ad;
        int                p, q, ecls, elat, cyc, wr0, fill0;
        logic [STAG_W-1:0] s;
        logic [DATA_W-1:0] edata;
        string             rq;
        ad = addr_t'(a);
        p  = int'(ad.idx);
        q  = int'(partner_idx(ad.idx));
        s  = stored_tag(ad);
        edata = gmem[a];
        if (mv[p] && ms[p] == s) begin
            ecls = 1; elat = 1; rq = "R1";
        end else if (mv[q] && ms[q] == s) begin
            ecls = 2; elat = 2; rq = "R3";
        end else if (we) begin
            ecls = 3; elat = 2; rq = "R9";
        end else begin
            ecls = 3; elat = MEM_LAT + 2; rq = "R5";
        end
        wr0 = wr_cnt;
        fill0 = fill_cnt;
        @(negedge clk);
        cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = wd;
        @(negedge clk);
        cpu_req = 1'b0;
        cyc = 1;
        while (!cpu_done && cyc < 200) begin
            @(negedge clk);
            cyc++;
        end
        #1;
        check(cpu_class == 2'(ecls), rq, {ctx, " class"}, cpu_class, ecls);
        check(cyc == elat, rq, {ctx, " latency"}, cyc, elat);
        if (!we) begin
            check(cpu_rdata == edata, rq, {ctx, " read data"}, cpu_rdata, edata);
        end else begin
            check(wr_cnt == wr0 + 1, "R8", {ctx, " write pulses"}, wr_cnt - wr0, 1);
            check(gmem[a] == wd, "R8", {ctx, " written word"}, gmem[a], wd);
            if (ecls == 3) begin
                check(fill_cnt == fill0, "R9", {ctx, " fills on write miss"}, fill_cnt - fill0, 0);
            end
        end
        // reference slot update
        if (ecls == 2) begin
            bit                tv;
            logic [STAG_W-1:0] ts;
            tv = mv[p]; ts = ms[p];
            mv[p] = mv[q]; ms[p] = ms[q];
            mv[q] = tv; ms[q] = ts;
        end else if (ecls == 3 && !we) begin
            if (mv[p]) begin
                mv[q] = 1'b1; ms[q] = ms[p];
            end
            mv[p] = 1'b1; ms[p] = s;
        end
    endtask

    task automatic expect_cls(input logic [ADDR_W-1:0] a, input int cls, input string rq);
        addr_t ad;
        int    p, q, pc;
        ad = addr_t'(a);
        p  = int'(ad.idx);
        q  = int'(partner_idx(ad.idx));
        if (mv[p] && ms[p] == stored_tag(ad)) pc = 1;
        else if (mv[q] && ms[q] == stored_tag(ad)) pc = 2;
        else pc = 3;
        check(pc == cls, rq, "scenario model", pc, cls);
    endtask

    initial begin
        logic [ADDR_W-1:0] xa, xb, xc, xx, xw;
        for (int i = 0; i < MEM_SIZE; i++) gmem[i] = 32'h1000_0000 ^ (i * 32'h0001_0003);
        for (int i = 0; i < LINES; i++) begin mv[i] = 1'b0; ms[i] = '0; end
        void'($urandom(SEED));
        repeat (4) @(negedge clk);
        // R10: reset state
        check(cpu_done == 1'b0, "R10", "done in reset", cpu_done, 0);
        check(cpu_class == 2'b00, "R10", "class in reset", cpu_class, 0);
        check(mem_rd_req == 1'b0 && mem_wr == 1'b0, "R10", "memory strobes in reset",
              {mem_rd_req, mem_wr}, 0);
        rst = 1'b0;
        repeat (2) @(negedge clk);
        check(cpu_class == 2'b00, "R10", "class idle after reset", cpu_class, 0);

        xa = mk(5, 2, 0);
        xb = mk(9, 2, 1);
        xc = mk(12, 2, 0);
        xx = mk(5, 6, 1);
        xw = mk(33, 3, 0);

        expect_cls(xa, 3, "R5");  access(0, xa, 0, "cold read A");
        expect_cls(xa, 1, "R1");  access(0, xa, 0, "repeat A");
        expect_cls(xb, 3, "R7");  access(0, xb, 0, "conflict B pushes A to partner");
        expect_cls(xa, 2, "R2");  access(0, xa, 0, "A from partner slot");
        expect_cls(xa, 1, "R4");  access(0, xa, 0, "A fast after swap");
        expect_cls(xb, 2, "R4");  access(0, xb, 0, "B now in partner");
        expect_cls(xc, 3, "R7");  access(0, xc, 0, "third block C");
        expect_cls(xa, 3, "R7");  access(0, xa, 0, "A evicted by C");
        expect_cls(xx, 3, "R6");  access(0, xx, 0, "top index bit differs from A");
        expect_cls(xx, 1, "R8");  access(1, xx, 32'hDEAD_BEEF, "write fast hit");
        access(0, xx, 0, "read after write hit R8");
        access(0, xb, 0, "B back into primary");
        expect_cls(xc, 2, "R8");  access(1, xc, 32'h0BAD_F00D, "write pseudo-hit");
        expect_cls(xc, 1, "R4");  access(0, xc, 0, "read after write pseudo-hit R8");
        expect_cls(xw, 3, "R9");  access(1, xw, 32'h1234_5678, "write miss");
        expect_cls(xw, 3, "R9");  access(0, xw, 0, "read after write miss R5");

        for (int n = 0; n < 400; n++) begin
            bit                we;
            logic [ADDR_W-1:0] a;
            a  = mk(int'($urandom_range(3, 0)), int'($urandom_range(LINES - 1, 0)),
                    int'($urandom_range(LINE_WORDS - 1, 0)));
            we = ($urandom_range(3, 0) == 0);
            access(we, a, $urandom(), "random");
        end

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(8 * 150000);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule